// File: doc/BRIEF.md
# Complement-Checked Configuration Byte Loader

After every reset this block reads a fixed image of non-volatile configuration bytes over a one-cycle-latency byte-read port. Each setting in the image is stored as a value byte followed by its bitwise inverse. The block checks every pair. A pair that does not check out loads as all ones and sets a sticky error bit. An all-ones pair, which is what erased storage holds, loads as all ones with no error.

Once the whole image has been walked, the block raises `done` and publishes the validated settings to the rest of the chip. These are a read-protection flag, four user control bits, a user data word and an active-low write-protect mask. Until then every output holds its safe value: protection on, every region locked, and user controls and data at zero.

Top module: `optcfg_loader`

## Requirements
- R1: After reset is released, the block waits one cycle and then asserts `rd_en` for exactly 16 consecutive cycles, with `rd_addr` running 0,1,...,15 in ascending order. It makes no further reads until the next reset.
- R2: `done` is low out of reset and rises 18 clock cycles after reset release, counting the edge that first samples `rst_n` high. It stays high until the next reset.
- R3: While `done` is low, `rdprot_on`=1, `wp_mask`=0, `user_data`=0 and `wdg_sw`=`keep_on_dsleep`=`keep_on_stdby`=`boot_bank0`=0.
- R4: A pair is valid when the byte at even offset 2k equals the bitwise inverse of the byte at offset 2k+1. A valid pair loads its value byte unchanged.
- R5: A pair that is neither valid nor all-ones loads as 0xFF and sets `cfg_err`.
- R6: A pair whose value and complement bytes are both 0xFF loads as 0xFF and does not set `cfg_err`.
- R7: After `done`, `rdprot_on` is 0 only when the loaded security setting (pair 0, offset 0) equals 0xA5. Any other value, including a forced 0xFF, gives 1.
- R8: The user control setting is pair 1 (offset 2). Bit 0 drives `wdg_sw` (1 = software watchdog), bit 1 drives `keep_on_dsleep` (0 = reset instead of deep-sleep), bit 2 drives `keep_on_stdby` (0 = reset instead of standby), and bit 3 drives `boot_bank0`. Bits 7:4 have no effect on any output.
- R9: `user_data` = {byte at offset 6, byte at offset 4}. `wp_mask` = {offset 14, offset 12, offset 10, offset 8}. A 0 bit in `wp_mask` means its 4 KB region is protected.
- R10: `cfg_err` is the OR of the mismatch results of all eight pairs. It stays set until reset, and a reset followed by a clean image clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; starts a reload |
| rd_en | output | 1 | Byte read request to the storage array |
| rd_addr | output | 4 | Byte offset being read |
| rd_data | input | 8 | Byte returned one cycle after the request |
| done | output | 1 | Image fully loaded and checked |
| rdprot_on | output | 1 | Read protection active |
| wdg_sw | output | 1 | 1 = software-started watchdog, 0 = always-on watchdog |
| keep_on_dsleep | output | 1 | 0 = reset instead of entering deep-sleep |
| keep_on_stdby | output | 1 | 0 = reset instead of entering standby |
| boot_bank0 | output | 1 | Boot bank select |
| user_data | output | 16 | User data word |
| wp_mask | output | 32 | Write-protect mask, active low |
| cfg_err | output | 1 | Sticky complement-mismatch status |

## Verification
A slip in the read sequencer shows on `rd_addr` and `rd_en` in the very cycle it happens. It also moves the `done` edge away from cycle 18 after reset release. A capture that pairs the wrong bytes or writes the wrong slot shows only once `done` rises: a field on the published outputs holds a neighbour's value or a forced 0xFF, and `cfg_err` is raised or missed. Each directed image is therefore chosen so that every field carries a distinct value. A gating fault is visible before `done` as a published output leaving its safe default in the middle of the load.

// File: rtl/optcfg_pkg.sv
package optcfg_pkg;

   typedef enum logic [1:0] {
      SQ_ARM  = 2'd0,
      SQ_READ = 2'd1,
      SQ_IDLE = 2'd2
   } seq_state_e;

   localparam int unsigned SLOT_SEC  = 0;
   localparam int unsigned SLOT_USER = 1;
   localparam int unsigned SLOT_DATA = 2;

   function automatic int unsigned slot_count(input int unsigned data_bytes,
                                              input int unsigned wp_bytes);
      return 2 + data_bytes + wp_bytes;
   endfunction

endpackage

// File: rtl/optcfg_seq.sv
module optcfg_seq
   import optcfg_pkg::*;
#(
   parameter int unsigned NUM_BYTES = 16,
   parameter int unsigned ADDR_W    = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr
);

   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_BYTES - 1);

   seq_state_e        state_q;
   logic [ADDR_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_ARM;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            SQ_ARM:  state_q <= SQ_READ;
            SQ_READ: begin
               if (cnt_q == LAST_ADDR) begin
                  state_q <= SQ_IDLE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign rd_en   = (state_q == SQ_READ);
   assign rd_addr = cnt_q;

   // R1: consecutive reads step by one address
   p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + 1'b1));

   // R1: the read burst starts at offset zero
   p_start_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_en) |-> (rd_addr == '0));

   // R1: the last offset ends the burst
   p_single_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == LAST_ADDR) |=> !rd_en);

endmodule

// File: rtl/optcfg_pair_check.sv
module optcfg_pair_check #(
   parameter int unsigned BYTE_W = 8
)(
   input  logic [BYTE_W-1:0] val,
   input  logic [BYTE_W-1:0] cmp,
   output logic [BYTE_W-1:0] fixed,
   output logic              bad
);

   logic inverse_ok;
   logic erased;

   always_comb begin
      inverse_ok = (val == ~cmp);
      erased     = (&val) && (&cmp);
      fixed      = inverse_ok ? val : {BYTE_W{1'b1}};
      bad        = !inverse_ok && !erased;
   end

endmodule

// File: rtl/optcfg_capture.sv
module optcfg_capture #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned ADDR_W = 4,
   localparam int unsigned IDX_W = ADDR_W - 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [BYTE_W-1:0] wr_val,
   output logic              wr_bad
);

   logic              pend_q;
   logic [ADDR_W-1:0] addr_q;
   logic [BYTE_W-1:0] held_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         addr_q <= '0;
      end else begin
         pend_q <= rd_en;
         addr_q <= rd_addr;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= '0;
      end else if (pend_q && !addr_q[0]) begin
         held_q <= rd_data;
      end
   end

   optcfg_pair_check #(.BYTE_W(BYTE_W)) u_check (
      .val   (held_q),
      .cmp   (rd_data),
      .fixed (wr_val),
      .bad   (wr_bad)
   );

   assign wr_en  = pend_q && addr_q[0];
   assign wr_idx = addr_q[ADDR_W-1:1];

   // R5: a reported mismatch always carries the forced all-ones value
   p_bad_forces_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_bad) |-> (&wr_val));

endmodule

// File: rtl/optcfg_store.sv
module optcfg_store #(
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned NUM_PAIRS = 8,
   localparam int unsigned IDX_W    = $clog2(NUM_PAIRS)
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [IDX_W-1:0]            wr_idx,
   input  logic [BYTE_W-1:0]           wr_val,
   input  logic                        wr_bad,
   output logic [NUM_PAIRS*BYTE_W-1:0] slots,
   output logic                        done,
   output logic                        err
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PAIRS - 1);

   for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_slot
      logic [BYTE_W-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_q <= {BYTE_W{1'b1}};
         end else if (wr_en && wr_idx == IDX_W'(g)) begin
            slot_q <= wr_val;
         end
      end
      assign slots[g*BYTE_W +: BYTE_W] = slot_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done <= 1'b0;
         err  <= 1'b0;
      end else begin
         if (wr_en && wr_bad)            err  <= 1'b1;
         if (wr_en && wr_idx == LAST_IDX) done <= 1'b1;
      end
   end

   // R10: error status is sticky
   p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   // R5: a mismatch raises the error on the next cycle
   p_err_on_bad_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_bad) |=> err);

   // R2: done stays high once set
   p_done_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   // R1: no pair is written after the load has completed
   p_no_late_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !wr_en);

endmodule

// File: rtl/optcfg_loader.sv
module optcfg_loader
   import optcfg_pkg::*;
#(
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned DATA_BYTES  = 2,
   parameter int unsigned WP_BYTES    = 4,
   parameter logic [7:0]  UNLOCK_CODE = 8'hA5,
   localparam int unsigned NUM_PAIRS  = slot_count(DATA_BYTES, WP_BYTES),
   localparam int unsigned NUM_BYTES  = 2 * NUM_PAIRS,
   localparam int unsigned ADDR_W     = $clog2(NUM_BYTES),
   localparam int unsigned SLOT_WP    = SLOT_DATA + DATA_BYTES
)(
   input  logic                         clk,
   input  logic                         rst_n,
   output logic                         rd_en,
   output logic [ADDR_W-1:0]            rd_addr,
   input  logic [BYTE_W-1:0]            rd_data,
   output logic                         done,
   output logic                         rdprot_on,
   output logic                         wdg_sw,
   output logic                         keep_on_dsleep,
   output logic                         keep_on_stdby,
   output logic                         boot_bank0,
   output logic [DATA_BYTES*BYTE_W-1:0] user_data,
   output logic [WP_BYTES*BYTE_W-1:0]   wp_mask,
   output logic                         cfg_err
);

   if (BYTE_W < 8) begin : g_chk_bytew
      $error("optcfg_loader: BYTE_W must be at least 8");
   end
   if (WP_BYTES < 1 || DATA_BYTES < 1) begin : g_chk_fields
      $error("optcfg_loader: DATA_BYTES and WP_BYTES must be nonzero");
   end
   if ((1 << ADDR_W) != NUM_BYTES) begin : g_chk_pow2
      $error("optcfg_loader: pair count must give a power-of-two image");
   end

   logic                        wr_en;
   logic [ADDR_W-2:0]           wr_idx;
   logic [BYTE_W-1:0]           wr_val;
   logic                        wr_bad;
   logic [NUM_PAIRS*BYTE_W-1:0] slots;
   logic                        loaded;

   optcfg_seq #(.NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .rd_addr (rd_addr)
   );

   optcfg_capture #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_val  (wr_val),
      .wr_bad  (wr_bad)
   );

   optcfg_store #(.BYTE_W(BYTE_W), .NUM_PAIRS(NUM_PAIRS)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .wr_val (wr_val),
      .wr_bad (wr_bad),
      .slots  (slots),
      .done   (loaded),
      .err    (cfg_err)
   );

   logic [BYTE_W-1:0] sec_byte;
   logic [BYTE_W-1:0] user_byte;
   logic [3:0]        unused_user_hi;

   assign sec_byte       = slots[SLOT_SEC*BYTE_W +: BYTE_W];
   assign user_byte      = slots[SLOT_USER*BYTE_W +: BYTE_W];
   assign unused_user_hi = user_byte[7:4];

   assign done           = loaded;
   assign rdprot_on      = !loaded || (sec_byte != BYTE_W'(UNLOCK_CODE));
   assign wdg_sw         = loaded & user_byte[0];
   assign keep_on_dsleep = loaded & user_byte[1];
   assign keep_on_stdby  = loaded & user_byte[2];
   assign boot_bank0     = loaded & user_byte[3];

   for (genvar d = 0; d < DATA_BYTES; d++) begin : g_data
      assign user_data[d*BYTE_W +: BYTE_W] =
         loaded ? slots[(SLOT_DATA+d)*BYTE_W +: BYTE_W] : '0;
   end

   for (genvar w = 0; w < WP_BYTES; w++) begin : g_wp
      assign wp_mask[w*BYTE_W +: BYTE_W] =
         loaded ? slots[(SLOT_WP+w)*BYTE_W +: BYTE_W] : '0;
   end

   // R3: safe defaults until the load completes
   p_safe_defaults_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (rdprot_on && wp_mask == '0 && user_data == '0 && !wdg_sw));

   // R7: protection is released only after the load has completed
   p_unlock_needs_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rdprot_on |-> done);

endmodule

// File: tb/optcfg_loader_tb.sv
module optcfg_loader_tb;

   logic        clk;
   logic        rst_n;
   logic        rd_en;
   logic [3:0]  rd_addr;
   logic [7:0]  rd_data;
   logic        done;
   logic        rdprot_on;
   logic        wdg_sw;
   logic        keep_on_dsleep;
   logic        keep_on_stdby;
   logic        boot_bank0;
   logic [15:0] user_data;
   logic [31:0] wp_mask;
   logic        cfg_err;

   int n_run;
   int n_fail;

   logic [7:0] img [16];
   logic [3:0] rlog [32];
   int         nlog;

   optcfg_loader u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .rd_en          (rd_en),
      .rd_addr        (rd_addr),
      .rd_data        (rd_data),
      .done           (done),
      .rdprot_on      (rdprot_on),
      .wdg_sw         (wdg_sw),
      .keep_on_dsleep (keep_on_dsleep),
      .keep_on_stdby  (keep_on_stdby),
      .boot_bank0     (boot_bank0),
      .user_data      (user_data),
      .wp_mask        (wp_mask),
      .cfg_err        (cfg_err)
   );

   initial clk = 1'b0;
   always #2 clk = ~clk;

   // storage model: registered read, one cycle of latency
   always @(posedge clk) begin
      if (rd_en) begin
         rd_data <= img[rd_addr];
         if (nlog < 32) rlog[nlog] <= rd_addr;
         nlog <= nlog + 1;
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic set_pair(input int k, input logic [7:0] v);
      img[2*k]   = v;
      img[2*k+1] = ~v;
   endtask

   task automatic set_image(input logic [7:0] sec, input logic [7:0] usr,
                            input logic [15:0] dat, input logic [31:0] wp);
      set_pair(0, sec);
      set_pair(1, usr);
      set_pair(2, dat[7:0]);
      set_pair(3, dat[15:8]);
      for (int i = 0; i < 4; i++) set_pair(4 + i, wp[8*i +: 8]);
   endtask

   // reset, then load; checks timing and safe defaults on the way
   task automatic do_load(input string tag);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      nlog  = 0;
      rst_n = 1'b1;
      @(negedge clk);
      chk({tag, " R2 done low after reset"}, done, 0);
      chk({tag, " R3 safe defaults early"},
          {rdprot_on, wp_mask, user_data, wdg_sw, keep_on_dsleep, keep_on_stdby, boot_bank0},
          {1'b1, 32'h0, 16'h0, 4'h0});
      repeat (9) @(negedge clk);
      chk({tag, " R3 safe defaults mid-load"}, {done, rdprot_on, wp_mask}, {1'b0, 1'b1, 32'h0});
      repeat (7) @(negedge clk);
      chk({tag, " R2 done low at cycle 17"}, done, 0);
      @(negedge clk);
      chk({tag, " R2 done high at cycle 18"}, done, 1);
   endtask

   // expected outputs from the image contents, per the requirements
   task automatic check_outputs(input string tag);
      logic [7:0] eb [8];
      logic       eerr;
      eerr = 1'b0;
      for (int k = 0; k < 8; k++) begin
         if (img[2*k] == ~img[2*k+1]) begin
            eb[k] = img[2*k];
         end else begin
            eb[k] = 8'hFF;
            if (!(img[2*k] == 8'hFF && img[2*k+1] == 8'hFF)) eerr = 1'b1;
         end
      end
      chk({tag, " R7 rdprot_on"}, rdprot_on, (eb[0] != 8'hA5));
      chk({tag, " R8 user bits"}, {boot_bank0, keep_on_stdby, keep_on_dsleep, wdg_sw}, eb[1][3:0]);
      chk({tag, " R9 user_data"}, user_data, {eb[3], eb[2]});
      chk({tag, " R9 wp_mask"}, wp_mask, {eb[7], eb[6], eb[5], eb[4]});
      chk({tag, " R5 R6 R10 cfg_err"}, cfg_err, eerr);
   endtask

   task automatic t_valid();
      set_image(8'hA5, 8'hF5, 16'h1234, 32'h0F0F_A55A);
      do_load("valid");
      check_outputs("valid");
      chk("valid R4 user_data literal", user_data, 16'h1234);
      chk("valid R9 wp_mask literal", wp_mask, 32'h0F0F_A55A);
      chk("valid R7 unlocked", rdprot_on, 0);
      chk("valid R8 bits 7:4 ignored", {boot_bank0, keep_on_stdby, keep_on_dsleep, wdg_sw}, 4'h5);
      chk("valid R1 read count", nlog, 16);
      for (int i = 0; i < 16; i++) chk("valid R1 read order", rlog[i], i[3:0]);
      repeat (6) @(negedge clk);
      chk("valid R1 no extra reads", nlog, 16);
      chk("valid R2 done holds", done, 1);
   endtask

   task automatic t_bad_cmp();
      set_image(8'hA5, 8'h05, 16'hBEEF, 32'h1122_3344);
      img[11] = 8'h00;
      do_load("badcmp");
      check_outputs("badcmp");
      chk("badcmp R5 forced byte", wp_mask, 32'h1122_FF44);
      chk("badcmp R5 error set", cfg_err, 1);
      chk("badcmp R8 upper bits zero ignored", {boot_bank0, keep_on_stdby, keep_on_dsleep, wdg_sw}, 4'h5);
      repeat (5) @(negedge clk);
      chk("badcmp R10 sticky", cfg_err, 1);
   endtask

   task automatic t_erased();
      for (int i = 0; i < 16; i++) img[i] = 8'hFF;
      do_load("erased");
      check_outputs("erased");
      chk("erased R6 no error", cfg_err, 0);
      chk("erased R6 wp all ones", wp_mask, 32'hFFFF_FFFF);
      chk("erased R7 protected", rdprot_on, 1);
   endtask

   task automatic t_sec_other();
      set_image(8'h5A, 8'h0A, 16'h00FF, 32'h8000_0001);
      do_load("sec");
      check_outputs("sec");
      chk("sec R7 other value protects", rdprot_on, 1);
      chk("sec R4 no error", cfg_err, 0);
   endtask

   task automatic t_sec_bad();
      set_image(8'hA5, 8'h0C, 16'h5AA5, 32'hFFFF_0000);
      img[1] = 8'h5B;
      img[3] = 8'hFF;
      do_load("secbad");
      check_outputs("secbad");
      chk("secbad R7 forced 0xFF protects", rdprot_on, 1);
      chk("secbad R5 user forced ones", {boot_bank0, keep_on_stdby, keep_on_dsleep, wdg_sw}, 4'hF);
   endtask

   task automatic t_reload();
      set_image(8'hA5, 8'h00, 16'hC0DE, 32'h7654_3210);
      do_load("reload");
      check_outputs("reload");
      chk("reload R10 error cleared", cfg_err, 0);
   endtask

   initial begin
      n_run  = 0;
      n_fail = 0;
      nlog   = 0;
      rst_n  = 1'b0;
      for (int i = 0; i < 16; i++) img[i] = 8'hFF;
      t_valid();
      t_bad_cmp();
      t_erased();
      t_sec_other();
      t_sec_bad();
      t_reload();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #100000;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule